// File: doc/BRIEF.md
# Pad-Interleaved Sample Readout Sequencer

This block drains the stored samples of a front-end board over one serial channel. The board has a number of analog pads, 16 by default. Each pad keeps a fixed number of time-bin samples, 250 by default, in switched-capacitor storage. After a start request the sequencer steps a pad address and a bin address in bin-major order. For each bin it presents every pad, then it moves to the next bin. The analog storage, the ADC and the cable driver are modelled as a sample input that follows the presented address in the same cycle. That sample is forwarded on a valid/ready output stream, with one flag on the first word of the event and one on the final word.

The output stream obeys back-pressure. While `m_valid_o` is high and `m_ready_i` is low, the address, the data and both flags hold, and nothing advances. A word counts as transferred only in a cycle where valid and ready are both high. The valid signal is never withdrawn before its transfer.

A separate length checker sits on the receiving end of the channel. It always accepts words, so it has no ready pin. It counts the words that arrive with `s_valid_i`. At the word marked `s_last_i` it compares the total with the expected event size, pads × bins. Any difference sets a sticky error flag, and only reset clears that flag.

Top module: `padmux_seq`

## Requirements
- R1: Synchronous reset (active high `rst`) leaves the block idle. In that state `busy_o`, `done_o`, `m_valid_o` and `len_err_o` are 0, and both `pad_sel_o` and `bin_sel_o` are 0.
- R2: A high `start_i` in an idle cycle starts an event. From the next cycle `busy_o` and `m_valid_o` are 1, with pad 0, bin 0 presented.
- R3: The k-th transferred word (k from 0) carries `pad_sel_o` = k mod 16 and `bin_sel_o` = k div 16. The pad index wraps from 15 to 0, and the bin index steps only on that wrap, up to bin 249.
- R4: `m_first_o` is 1 only on word 0 (pad 0, bin 0). `m_last_o` is 1 only on word 3999 (pad 15, bin 249).
- R5: While `m_valid_o` is 1 and `m_ready_i` is 0, the address, flags and valid hold into the next cycle.
- R6: `m_data_o` equals `samp_i` in the same cycle, so it carries the sample of the presented address.
- R7: In the cycle after the last word is transferred, `done_o` is 1 for exactly one cycle, and `busy_o` and `m_valid_o` are 0.
- R8: `start_i` has no effect while an event is in progress. The word order continues unchanged, and only one `done_o` pulse follows.
- R9: The checker counts `s_valid_i` words. When a word marked `s_last_i` arrives, an event total other than 4000 sets `len_err_o` from the next cycle. Short and long events are both caught.
- R10: `len_err_o` stays set through later events of correct length and is cleared only by reset. An event of exactly 4000 words does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Readout request, honoured only when idle |
| samp_i | input | 12 | Sample of the presented pad/bin address |
| m_ready_i | input | 1 | Output stream ready |
| busy_o | output | 1 | Event in progress |
| done_o | output | 1 | One-cycle pulse after the final transfer |
| pad_sel_o | output | 4 | Pad address presented to storage |
| bin_sel_o | output | 8 | Time-bin address presented to storage |
| m_valid_o | output | 1 | Output stream valid |
| m_data_o | output | 12 | Output stream sample |
| m_first_o | output | 1 | Marks the first word of the event |
| m_last_o | output | 1 | Marks the final word of the event |
| s_valid_i | input | 1 | Received word strobe at the checker |
| s_last_i | input | 1 | Marks the received word that ends an event |
| len_err_o | output | 1 | Sticky event-length mismatch flag |

## Verification
On every cycle, the assertions check these properties:
- the pad index stays within range, and the bin steps exactly at a pad wrap;
- a stall freezes the address and valid;
- `done_o` follows the final transfer as a single pulse;
- a start during an event leaves the event running;
- the mismatch flag never drops on its own.

The complete bin-major order across all 4000 words, the data routing and the first/last flags need the bench. It checks each presented word against an index it computes itself, under random back-pressure. Caught short and long events, and a correct event that leaves the flag alone, also show only in the bench's directed scenarios.

// File: rtl/padmux_pkg.sv
package padmux_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_t;
endpackage

// File: rtl/padmux_addr_gen.sv
module padmux_addr_gen #(
  parameter int N_PADS = 16,
  parameter int N_BINS = 250,
  parameter int PAD_W  = 4,
  parameter int BIN_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             step_i,
  output logic [PAD_W-1:0] pad_o,
  output logic [BIN_W-1:0] bin_o,
  output logic             first_o,
  output logic             final_o
);
  localparam logic [PAD_W-1:0] PAD_MAX = PAD_W'(N_PADS - 1);
  localparam logic [BIN_W-1:0] BIN_MAX = BIN_W'(N_BINS - 1);

  logic [PAD_W-1:0] pad_q;
  logic [BIN_W-1:0] bin_q;
  logic             pad_wrap;

  assign pad_wrap = (pad_q == PAD_MAX);

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      pad_q <= '0;
      bin_q <= '0;
    end else if (step_i) begin
      if (pad_wrap) begin
        pad_q <= '0;
        bin_q <= (bin_q == BIN_MAX) ? '0 : bin_q + 1'b1;
      end else begin
        pad_q <= pad_q + 1'b1;
      end
    end
  end

  assign pad_o   = pad_q;
  assign bin_o   = bin_q;
  assign first_o = (pad_q == '0) && (bin_q == '0);
  assign final_o = pad_wrap && (bin_q == BIN_MAX);

  AST_PAD_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    32'(pad_q) < N_PADS); // R3

  AST_BIN_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step_i && !clear_i && pad_wrap && bin_q != BIN_MAX)
      |=> (pad_q == '0) && (bin_q == $past(bin_q) + 1'b1)); // R3

  AST_BIN_STILL: assert property (@(posedge clk) disable iff (rst)
    (step_i && !clear_i && !pad_wrap) |=> $stable(bin_q)); // R3
endmodule

// File: rtl/padmux_seq_ctrl.sv
module padmux_seq_ctrl
  import padmux_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic xfer_i,
  input  logic final_i,
  output logic busy_o,
  output logic done_o,
  output logic clear_o
);
  seq_state_t state_q;
  logic       done_q;
  logic       end_xfer;

  assign end_xfer = (state_q == ST_RUN) && xfer_i && final_i;
  assign clear_o  = (state_q == ST_IDLE) && start_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      done_q <= end_xfer;
      case (state_q)
        ST_IDLE: if (start_i)  state_q <= ST_RUN;
        ST_RUN:  if (end_xfer) state_q <= ST_IDLE;
        default:               state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == ST_RUN);
  assign done_o = done_q;

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !end_xfer) |=> busy_o); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o); // R7
endmodule

// File: rtl/padmux_len_check.sv
module padmux_len_check #(
  parameter int EXP_LEN = 4000
) (
  input  logic clk,
  input  logic rst,
  input  logic valid_i,
  input  logic last_i,
  output logic err_o
);
  localparam int CNT_W = $clog2(EXP_LEN + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   total;
  logic             err_q;

  assign total = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (valid_i) begin
      if (last_i) begin
        cnt_q <= '0;
        if (total != (CNT_W+1)'(EXP_LEN)) err_q <= 1'b1;
      end else if (cnt_q != CNT_TOP) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign err_o = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q); // R10

  AST_COUNT_RESTART: assert property (@(posedge clk) disable iff (rst)
    (valid_i && last_i) |=> (cnt_q == '0)); // R9
endmodule

// File: rtl/padmux_seq.sv
module padmux_seq #(
  parameter int N_PADS = 16,
  parameter int N_BINS = 250,
  parameter int DW     = 12,
  parameter int PAD_W  = $clog2(N_PADS),
  parameter int BIN_W  = $clog2(N_BINS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [DW-1:0]    samp_i,
  input  logic             m_ready_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [PAD_W-1:0] pad_sel_o,
  output logic [BIN_W-1:0] bin_sel_o,
  output logic             m_valid_o,
  output logic [DW-1:0]    m_data_o,
  output logic             m_first_o,
  output logic             m_last_o,
  input  logic             s_valid_i,
  input  logic             s_last_i,
  output logic             len_err_o
);
  localparam int EVT_LEN = N_PADS * N_BINS;

  logic xfer, clear, first_w, final_w, busy_w;

  assign m_valid_o = busy_w;
  assign busy_o    = busy_w;
  assign xfer      = busy_w && m_ready_i;
  assign m_data_o  = samp_i;
  assign m_first_o = busy_w && first_w;
  assign m_last_o  = busy_w && final_w;

  padmux_addr_gen #(
    .N_PADS(N_PADS), .N_BINS(N_BINS), .PAD_W(PAD_W), .BIN_W(BIN_W)
  ) u_addr (
    .clk(clk), .rst(rst), .clear_i(clear), .step_i(xfer),
    .pad_o(pad_sel_o), .bin_o(bin_sel_o),
    .first_o(first_w), .final_o(final_w)
  );

  padmux_seq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .xfer_i(xfer),
    .final_i(final_w), .busy_o(busy_w), .done_o(done_o), .clear_o(clear)
  );

  padmux_len_check #(.EXP_LEN(EVT_LEN)) u_chk (
    .clk(clk), .rst(rst), .valid_i(s_valid_i), .last_i(s_last_i),
    .err_o(len_err_o)
  );

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
    (m_valid_o && !m_ready_i)
      |=> m_valid_o && $stable(pad_sel_o) && $stable(bin_sel_o)); // R5

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (m_valid_o && m_ready_i && m_last_o) |=> done_o && !m_valid_o); // R7

  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> m_valid_o && m_first_o); // R2
endmodule

// File: tb/sim_padmux_seq.sv
module sim_padmux_seq;
  localparam int NP = 16;
  localparam int NB = 250;
  localparam int TOTAL = NP * NB;

  logic clk = 1'b0;
  logic rst, start, m_ready, tb_loop, tb_sv, tb_sl;
  logic [11:0] samp, m_data;
  logic busy, done, m_valid, m_first, m_last, len_err, s_valid, s_last;
  logic [3:0] pad;
  logic [7:0] bin;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  function automatic logic [11:0] model(int p, int b);
    return 12'((b * 37 + p * 5) ^ 12'h5A3);
  endfunction

  assign samp    = model(int'(pad), int'(bin));
  assign s_valid = tb_loop ? (m_valid && m_ready) : tb_sv;
  assign s_last  = tb_loop ? (m_valid && m_ready && m_last) : tb_sl;

  padmux_seq u0 (
    .clk(clk), .rst(rst), .start_i(start), .samp_i(samp), .m_ready_i(m_ready),
    .busy_o(busy), .done_o(done), .pad_sel_o(pad), .bin_sel_o(bin),
    .m_valid_o(m_valid), .m_data_o(m_data), .m_first_o(m_first),
    .m_last_o(m_last), .s_valid_i(s_valid), .s_last_i(s_last),
    .len_err_o(len_err)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic check_reset_state();
    check(!busy && !done && !m_valid, "R1 idle", {busy, done, m_valid}, 0);
    check(pad == 0 && bin == 0, "R1 counters", int'(bin) * NP + int'(pad), 0);
    check(!len_err, "R1 err", int'(len_err), 0);
  endtask

  task automatic run_event(int ready_pct, int mid_start);
    int idx = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && m_valid, "R2 started", {busy, m_valid}, 3);
    while (idx < TOTAL) begin
      check(m_valid, "R5 valid held", int'(m_valid), 1);
      check(int'(bin) * NP + int'(pad) == idx, "R3 order",
            int'(bin) * NP + int'(pad), idx);
      check({m_first, m_last} == {idx == 0, idx == TOTAL - 1}, "R4 flags",
            {m_first, m_last}, {idx == 0, idx == TOTAL - 1});
      check(m_data == model(idx % NP, idx / NP), "R6 data",
            int'(m_data), int'(model(idx % NP, idx / NP)));
      check(!done, "R8 no early done", int'(done), 0);
      m_ready = (int'($urandom % 100) < ready_pct);
      start = (mid_start != 0) && (idx >= 1000) && (idx < 1010);
      if (m_ready) idx++;
      @(negedge clk);
    end
    m_ready = 1'b0;
    start = 1'b0;
    check(done && !busy && !m_valid, "R7 done", {done, busy, m_valid}, 4);
    @(negedge clk);
    check(!done, "R7 single pulse", int'(done), 0);
  endtask

  task automatic send_words(int n);
    for (int i = 0; i < n; i++) begin
      while (($urandom % 4) == 0) begin
        tb_sv = 1'b0;
        tb_sl = 1'b0;
        @(negedge clk);
      end
      tb_sv = 1'b1;
      tb_sl = (i == n - 1);
      @(negedge clk);
    end
    tb_sv = 1'b0;
    tb_sl = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; start = 1'b0; m_ready = 1'b0;
    tb_loop = 1'b1; tb_sv = 1'b0; tb_sl = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_reset_state();

    run_event(60, 0);
    check(!len_err, "R10 correct loopback event", int'(len_err), 0);
    run_event(85, 1);
    check(!len_err, "R8 R9 second event", int'(len_err), 0);

    tb_loop = 1'b0;
    send_words(TOTAL);
    @(negedge clk);
    check(!len_err, "R10 exact length", int'(len_err), 0);
    send_words(TOTAL - 1);
    check(len_err, "R9 short event", int'(len_err), 1);
    send_words(TOTAL);
    check(len_err, "R10 sticky", int'(len_err), 1);

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_reset_state();
    send_words(TOTAL + 1);
    check(len_err, "R9 long event", int'(len_err), 1);
    send_words(1);
    check(len_err, "R9 one-word event", int'(len_err), 1);
    summary();
  end
endmodule